// File: doc/BRIEF.md
# Load/Store Address Generator with Base Writeback

This block computes the memory address for a single load or store instruction. It is purely combinational. It takes the 32-bit instruction word, the instruction address, the values read for the base and index registers, and the carry flag. From these it produces the access address, a base-writeback enable, the value to write back to the base register, and a flag that marks an unprivileged (user-translated) access.

Two offset encodings share one indexing scheme. The word/byte form carries either a 12-bit immediate or an index register scaled by a shift that has an immediate amount. The halfword/signed form carries either an 8-bit immediate split across two nibbles or an unshifted index register. In both forms, the indexing bits choose between two modes:

- **Pre-indexing:** the offset is applied before the access, and writeback is optional.
- **Post-indexing:** the access uses the unmodified base, and the updated base is always written back.

The block sits between register read and the memory request stage of a pipeline.

Top module: `lsu_agen`

## Requirements
- R1: With insn[24]=1 (pre-indexed), mem_addr equals the base adjusted by the offset, wb_value equals mem_addr, and wb_en equals insn[21].
- R2: With insn[24]=0 (post-indexed), mem_addr equals the unmodified base, wb_en is 1, and wb_value equals the base adjusted by the offset.
- R3: insn[23]=1 adds the offset to the base and insn[23]=0 subtracts it, both modulo 2^32.
- R4: When insn[27:26]=01 (word/byte form) and insn[25]=0, the offset is insn[11:0], zero-extended.
- R5: When insn[27:26]=01 and insn[25]=1, the offset is the index register shifted by insn[11:7]. The shift kind is insn[6:5]: 00 shift left, 01 logical right, 10 arithmetic right, 11 rotate right.
- R6: In the scaled form, an amount of 0 has special meanings. A logical right shift by 0 acts as a shift by 32 and gives 0. An arithmetic right shift by 0 gives 32 copies of the sign bit. A rotate by 0 gives {carry_in, index[31:1]}.
- R7: When insn[27:26] is not 01 (halfword/signed form), insn[22]=1 gives the offset {insn[11:8], insn[3:0]}, zero-extended. insn[22]=0 gives the unshifted index register.
- R8: user_xlate is 1 exactly for the word/byte form with insn[24]=0 and insn[21]=1, and writeback still occurs. In the halfword/signed form the same bits give a normal post-indexed access with user_xlate at 0.
- R9: When the base field insn[19:16] or the index field insn[3:0] is 15, that operand reads as pc_in + 8 instead of the supplied register value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| insn | input | 32 | Instruction word |
| pc_in | input | 32 | Address of the instruction |
| base_in | input | 32 | Value read for the base register field |
| index_in | input | 32 | Value read for the index register field |
| carry_in | input | 1 | Current carry flag, used by rotate-through-carry |
| mem_addr | output | 32 | Address of the memory access |
| wb_en | output | 1 | Base register writeback enable |
| wb_value | output | 32 | Value for base writeback (base adjusted by offset) |
| user_xlate | output | 1 | Access uses unprivileged translation |

## Verification
The bench builds the block with its default parameters: a 32-bit datapath, a program-counter bias of 8, and the halfword/signed form enabled. These values bring within reach both offset encodings, and the program-counter substitution on either operand field with a realistic bias. They also make the zero-amount shifts reach the shift-by-32 edge exactly at the width of the datapath. The stimulus favours the boundary encodings: amount 0 for each shift kind, with both carry values and both sign polarities, the largest 12-bit immediate, and a subtraction that wraps below zero.

// File: rtl/lsu_agen_pkg.sv
package lsu_agen_pkg;

   localparam int unsigned INSN_W    = 32;
   localparam int unsigned REGSEL_W  = 4;
   localparam int unsigned FIELD12_W = 12;
   localparam int unsigned AMT_W     = 5;

   // bit positions the decode depends on
   localparam int unsigned BIT_PRE    = 24;
   localparam int unsigned BIT_UP     = 23;
   localparam int unsigned BIT_HIMM   = 22;
   localparam int unsigned BIT_WB     = 21;
   localparam int unsigned BIT_REGOFF = 25;

   localparam logic [REGSEL_W-1:0] PC_SEL = 4'd15;

   typedef enum logic [1:0] {
      SCALE_LSL = 2'd0,
      SCALE_LSR = 2'd1,
      SCALE_ASR = 2'd2,
      SCALE_ROR = 2'd3
   } scale_kind_e;

endpackage

// File: rtl/lsu_agen_operand.sv
module lsu_agen_operand #(
   parameter int unsigned DATA_W  = 32,
   parameter int unsigned PC_BIAS = 8
) (
   input  logic [lsu_agen_pkg::REGSEL_W-1:0] reg_sel,
   input  logic [DATA_W-1:0]                 reg_value,
   input  logic [DATA_W-1:0]                 pc_value,
   output logic [DATA_W-1:0]                 value
);
   localparam logic [DATA_W-1:0] BIAS = DATA_W'(PC_BIAS);

   always_comb begin
      if (reg_sel == lsu_agen_pkg::PC_SEL) value = pc_value + BIAS;
      else                                 value = reg_value;
   end
endmodule

// File: rtl/lsu_agen_scaler.sv
module lsu_agen_scaler #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned AMT_W  = 5
) (
   input  logic [DATA_W-1:0]             src,
   input  lsu_agen_pkg::scale_kind_e     kind,
   input  logic [AMT_W-1:0]              amount,
   input  logic                          carry_in,
   output logic [DATA_W-1:0]             result
);
   import lsu_agen_pkg::*;

   localparam int unsigned EFF_W = AMT_W + 1;
   localparam logic [EFF_W-1:0] FULL_SHIFT = EFF_W'(1) << AMT_W;

   if (DATA_W < 2) begin : g_bad_width
      $error("lsu_agen_scaler: DATA_W must be at least 2");
   end

   logic [EFF_W-1:0]    eff_amt;
   logic [2*DATA_W-1:0] doubled;
   logic [DATA_W-1:0]   rotated;

   always_comb begin
      eff_amt = (amount == '0) ? FULL_SHIFT : {1'b0, amount};
      doubled = {src, src};
      rotated = DATA_W'(doubled >> amount);
      result  = src;
      case (kind)
         SCALE_LSL: result = src << amount;
         SCALE_LSR: result = src >> eff_amt;
         SCALE_ASR: result = DATA_W'($signed(src) >>> eff_amt);
         SCALE_ROR: begin
            if (amount == '0) result = {carry_in, src[DATA_W-1:1]};
            else              result = rotated;
         end
         default:   result = src;
      endcase
   end
endmodule

// File: rtl/lsu_agen_offset.sv
module lsu_agen_offset #(
   parameter int unsigned DATA_W       = 32,
   parameter bit          SUPPORT_HALF = 1'b1
) (
   input  logic                                  word_form,
   input  logic                                  reg_offset,
   input  logic                                  half_imm,
   input  logic [lsu_agen_pkg::FIELD12_W-1:0]    field,
   input  logic [DATA_W-1:0]                     index_val,
   input  logic                                  carry_in,
   output logic [DATA_W-1:0]                     offset
);
   import lsu_agen_pkg::*;

   localparam int unsigned NIB_W = 4;

   logic [DATA_W-1:0] scaled;
   logic [DATA_W-1:0] word_off;
   logic [DATA_W-1:0] half_off;

   lsu_agen_scaler #(
      .DATA_W (DATA_W),
      .AMT_W  (AMT_W)
   ) u_scaler (
      .src      (index_val),
      .kind     (scale_kind_e'(field[6:5])),
      .amount   (field[11:7]),
      .carry_in (carry_in),
      .result   (scaled)
   );

   always_comb word_off = reg_offset ? scaled : DATA_W'(field);

   if (SUPPORT_HALF) begin : g_half
      always_comb begin
         if (half_imm) half_off = DATA_W'({field[11:8], field[NIB_W-1:0]});
         else          half_off = index_val;
      end
   end else begin : g_word_only
      always_comb half_off = word_off;
   end

   always_comb offset = word_form ? word_off : half_off;
endmodule

// File: rtl/lsu_agen.sv
module lsu_agen #(
   parameter int unsigned DATA_W       = 32,
   parameter int unsigned PC_BIAS      = 8,
   parameter bit          SUPPORT_HALF = 1'b1
) (
   input  logic [31:0]       insn,
   input  logic [DATA_W-1:0] pc_in,
   input  logic [DATA_W-1:0] base_in,
   input  logic [DATA_W-1:0] index_in,
   input  logic              carry_in,
   output logic [DATA_W-1:0] mem_addr,
   output logic              wb_en,
   output logic [DATA_W-1:0] wb_value,
   output logic              user_xlate
);
   import lsu_agen_pkg::*;

   localparam int unsigned N_OPS  = 2;
   localparam int unsigned OP_BASE = 0;
   localparam int unsigned OP_IDX  = 1;

   if (DATA_W < INSN_W) begin : g_bad_width
      $error("lsu_agen: DATA_W must be at least the instruction width");
   end
   if ((PC_BIAS % 4) != 0) begin : g_bad_bias
      $error("lsu_agen: PC_BIAS must be word aligned");
   end

   logic [REGSEL_W-1:0] op_sel [N_OPS];
   logic [DATA_W-1:0]   op_raw [N_OPS];
   logic [DATA_W-1:0]   op_val [N_OPS];

   always_comb begin
      op_sel[OP_BASE] = insn[19:16];
      op_sel[OP_IDX]  = insn[3:0];
      op_raw[OP_BASE] = base_in;
      op_raw[OP_IDX]  = index_in;
   end

   for (genvar g = 0; g < N_OPS; g++) begin : g_op
      lsu_agen_operand #(
         .DATA_W  (DATA_W),
         .PC_BIAS (PC_BIAS)
      ) u_operand (
         .reg_sel   (op_sel[g]),
         .reg_value (op_raw[g]),
         .pc_value  (pc_in),
         .value     (op_val[g])
      );
   end

   logic word_form;
   logic pre_idx;
   logic add_dir;
   logic wb_req;
   logic [DATA_W-1:0] offset;
   logic [DATA_W-1:0] adjusted;
   logic unused_fields;

   always_comb begin
      word_form = (insn[27:26] == 2'b01) || !SUPPORT_HALF;
      pre_idx   = insn[BIT_PRE];
      add_dir   = insn[BIT_UP];
      wb_req    = insn[BIT_WB];
   end

   assign unused_fields = ^{insn[31:28], insn[20], insn[15:12]};

   lsu_agen_offset #(
      .DATA_W       (DATA_W),
      .SUPPORT_HALF (SUPPORT_HALF)
   ) u_offset (
      .word_form  (word_form),
      .reg_offset (insn[BIT_REGOFF]),
      .half_imm   (insn[BIT_HIMM]),
      .field      (insn[FIELD12_W-1:0]),
      .index_val  (op_val[OP_IDX]),
      .carry_in   (carry_in),
      .offset     (offset)
   );

   always_comb begin
      if (add_dir) adjusted = op_val[OP_BASE] + offset;
      else         adjusted = op_val[OP_BASE] - offset;
      mem_addr   = pre_idx ? adjusted : op_val[OP_BASE];
      wb_value   = adjusted;
      wb_en      = pre_idx ? wb_req : 1'b1;
      user_xlate = word_form && !pre_idx && wb_req;
   end
endmodule

// File: rtl/lsu_agen_checker.sv
module lsu_agen_checker #(
   parameter int unsigned DATA_W = 32
) (
   input logic [31:0]       insn,
   input logic [DATA_W-1:0] base_in,
   input logic [DATA_W-1:0] mem_addr,
   input logic              wb_en,
   input logic [DATA_W-1:0] wb_value,
   input logic              user_xlate
);
   logic known;
   logic rn_is_pc;
   logic [DATA_W-1:0] half_imm;

   always_comb begin
      known    = !$isunknown({insn, base_in, mem_addr, wb_en, wb_value, user_xlate});
      rn_is_pc = (insn[19:16] == 4'd15);
      half_imm = DATA_W'({insn[11:8], insn[3:0]});
      if (known) begin
         // R1: pre-indexed access writes back only on request
         assert_pre_wb_R1: assert (!insn[24] || (wb_en == insn[21]))
            else $error("pre-indexed writeback enable mismatch");
         // R1: pre-indexed address equals the writeback value
         assert_pre_addr_R1: assert (!insn[24] || (mem_addr == wb_value))
            else $error("pre-indexed address differs from writeback value");
         // R2: post-indexed always writes back, access at the base
         assert_post_base_R2: assert (insn[24] || (wb_en && (rn_is_pc || mem_addr == base_in)))
            else $error("post-indexed access not at base or no writeback");
         // R8: user translation only on word/byte post-indexed with bit 21
         assert_user_form_R8: assert (!user_xlate || (insn[27:26] == 2'b01 && !insn[24] && insn[21] && wb_en))
            else $error("user translation flag in wrong encoding");
         // R7: halfword immediate, pre-indexed, adding
         assert_half_imm_R7: assert (!(insn[27:26] != 2'b01 && insn[22] && insn[24] && insn[23] && !rn_is_pc)
                                     || (mem_addr == base_in + half_imm))
            else $error("halfword split immediate address mismatch");
      end
   end
endmodule

bind lsu_agen lsu_agen_checker #(.DATA_W(DATA_W)) u_lsu_agen_checker (
   .insn       (insn),
   .base_in    (base_in),
   .mem_addr   (mem_addr),
   .wb_en      (wb_en),
   .wb_value   (wb_value),
   .user_xlate (user_xlate)
);

// File: tb/lsu_agen_bench.sv
module lsu_agen_bench;

   typedef struct {
      string       req;
      logic [31:0] addr;
      logic        wb;
      logic [31:0] wbv;
      logic        usr;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] insn = '0;
   logic [31:0] pc_in = '0;
   logic [31:0] base_in = '0;
   logic [31:0] index_in = '0;
   logic        carry_in = 1'b0;
   logic [31:0] mem_addr;
   logic        wb_en;
   logic [31:0] wb_value;
   logic        user_xlate;

   int checks = 0;
   int fails = 0;
   bit done = 1'b0;
   exp_t expq[$];

   always #2 clk = ~clk;

   lsu_agen u_lsu_agen (
      .insn       (insn),
      .pc_in      (pc_in),
      .base_in    (base_in),
      .index_in   (index_in),
      .carry_in   (carry_in),
      .mem_addr   (mem_addr),
      .wb_en      (wb_en),
      .wb_value   (wb_value),
      .user_xlate (user_xlate)
   );

   // reference written from the requirements
   function automatic exp_t model(string req, logic [31:0] i, logic [31:0] pc,
                                  logic [31:0] b, logic [31:0] x, logic c);
      exp_t e;
      logic [31:0] bv, xv, off, sum;
      logic [63:0] wide;
      int amt;
      bit is_word;
      is_word = (i[27:26] == 2'b01);
      bv = (i[19:16] == 4'hF) ? pc + 32'd8 : b;
      xv = (i[3:0] == 4'hF) ? pc + 32'd8 : x;
      amt = int'(i[11:7]);
      if (is_word) begin
         if (!i[25]) off = {20'd0, i[11:0]};
         else begin
            case (i[6:5])
               2'd0: off = xv << amt;
               2'd1: off = (amt == 0) ? 32'd0 : xv >> amt;
               2'd2: off = (amt == 0) ? {32{xv[31]}} : 32'($signed(xv) >>> amt);
               default: begin
                  if (amt == 0) off = {c, xv[31:1]};
                  else begin
                     wide = {xv, xv} >> amt;
                     off = wide[31:0];
                  end
               end
            endcase
         end
      end else begin
         off = i[22] ? {24'd0, i[11:8], i[3:0]} : xv;
      end
      sum = i[23] ? bv + off : bv - off;
      e.req  = req;
      e.addr = i[24] ? sum : bv;
      e.wb   = i[24] ? i[21] : 1'b1;
      e.wbv  = sum;
      e.usr  = is_word && !i[24] && i[21];
      return e;
   endfunction

   function automatic logic [31:0] wform(bit p, bit u, bit w, bit r, logic [3:0] rn, logic [11:0] f);
      return {4'hE, 2'b01, r, p, u, 1'b0, w, 1'b1, rn, 4'd1, f};
   endfunction

   function automatic logic [11:0] scl(logic [4:0] amt, logic [1:0] kind, logic [3:0] rm);
      return {amt, kind, 1'b0, rm};
   endfunction

   function automatic logic [31:0] hform(bit p, bit u, bit im, bit w, logic [3:0] rn,
                                         logic [3:0] hi, logic [3:0] lo);
      return {4'hE, 3'b000, p, u, im, w, 1'b1, rn, 4'd2, hi, 4'b1011, lo};
   endfunction

   task automatic drive(string req, logic [31:0] i, logic [31:0] pc, logic [31:0] b,
                        logic [31:0] x, logic c);
      @(posedge clk);
      #1;
      insn = i; pc_in = pc; base_in = b; index_in = x; carry_in = c;
      expq.push_back(model(req, i, pc, b, x, c));
   endtask

   // monitor: compare away from the active edge
   always @(negedge clk) begin
      if (rst_n && expq.size() > 0) begin
         exp_t e;
         e = expq.pop_front();
         checks++;
         if (mem_addr !== e.addr || wb_en !== e.wb || wb_value !== e.wbv || user_xlate !== e.usr) begin
            fails++;
            $display("FAIL %s: got addr=%h wb=%b wbv=%h usr=%b, expected addr=%h wb=%b wbv=%h usr=%b",
                     e.req, mem_addr, wb_en, wb_value, user_xlate, e.addr, e.wb, e.wbv, e.usr);
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         fails++;
         $display("FAIL watchdog: got hung run, expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      rst_n = 1'b1;
      // reset-like all-zero word: halfword form, post-indexed (R2)
      drive("R2 zero word", 32'd0, 32'd0, 32'd0, 32'd0, 1'b0);
      drive("R1 pre add no wb", wform(1,1,0,0,4'd2,12'h123), 32'h100, 32'h1000, 32'h0, 1'b0);
      drive("R1 pre add wb", wform(1,1,1,0,4'd2,12'h040), 32'h100, 32'h2000, 32'h0, 1'b0);
      drive("R3 subtract wraps", wform(1,0,0,0,4'd2,12'hFFF), 32'h100, 32'h10, 32'h0, 1'b0);
      drive("R2 post add", wform(0,1,0,0,4'd5,12'h008), 32'h100, 32'h3000, 32'h0, 1'b0);
      drive("R4 max imm12", wform(1,1,0,0,4'd1,12'hFFF), 32'h100, 32'h8000_0000, 32'h0, 1'b0);
      drive("R5 lsl4", wform(1,1,0,1,4'd1,scl(5'd4,2'd0,4'd3)), 32'h0, 32'h100, 32'h0000_1234, 1'b0);
      drive("R5 lsr3", wform(1,1,0,1,4'd1,scl(5'd3,2'd1,4'd3)), 32'h0, 32'h100, 32'h8000_00F0, 1'b0);
      drive("R5 asr5", wform(1,0,0,1,4'd1,scl(5'd5,2'd2,4'd3)), 32'h0, 32'h100, 32'h8000_0400, 1'b0);
      drive("R5 ror8", wform(1,1,0,1,4'd1,scl(5'd8,2'd3,4'd3)), 32'h0, 32'h0, 32'h1234_56AB, 1'b0);
      drive("R6 lsr0", wform(1,1,0,1,4'd1,scl(5'd0,2'd1,4'd3)), 32'h0, 32'h500, 32'hFFFF_FFFF, 1'b1);
      drive("R6 asr0 neg", wform(1,1,0,1,4'd1,scl(5'd0,2'd2,4'd3)), 32'h0, 32'h500, 32'h8000_0000, 1'b0);
      drive("R6 asr0 pos", wform(1,1,0,1,4'd1,scl(5'd0,2'd2,4'd3)), 32'h0, 32'h500, 32'h7FFF_FFFF, 1'b0);
      drive("R6 rrx c1", wform(1,1,0,1,4'd1,scl(5'd0,2'd3,4'd3)), 32'h0, 32'h0, 32'h0000_0003, 1'b1);
      drive("R6 rrx c0", wform(1,1,0,1,4'd1,scl(5'd0,2'd3,4'd3)), 32'h0, 32'h0, 32'h8000_0002, 1'b0);
      drive("R7 half imm", hform(1,1,1,0,4'd4,4'hA,4'h5), 32'h0, 32'h4000, 32'hDEAD_BEEF, 1'b0);
      drive("R7 half reg post sub", hform(0,0,0,0,4'd4,4'h0,4'd6), 32'h0, 32'h4000, 32'h0000_0100, 1'b0);
      drive("R7 half reg pre wb", hform(1,1,0,1,4'd4,4'hF,4'd6), 32'h0, 32'h4000, 32'h0000_0010, 1'b1);
      drive("R8 word post user", wform(0,1,1,0,4'd3,12'h004), 32'h0, 32'h6000, 32'h0, 1'b0);
      drive("R8 half post bit21", hform(0,1,1,1,4'd3,4'h1,4'h2), 32'h0, 32'h6000, 32'h0, 1'b0);
      drive("R8 word pre wb no user", wform(1,1,1,0,4'd3,12'h004), 32'h0, 32'h6000, 32'h0, 1'b0);
      drive("R9 base is pc", wform(1,1,0,0,4'hF,12'h010), 32'h0000_0200, 32'hBAD0_BAD0, 32'h0, 1'b0);
      drive("R9 index is pc", hform(1,0,0,0,4'd2,4'h0,4'hF), 32'h0000_0300, 32'h1000, 32'hBAD0_BAD0, 1'b0);
      repeat (3) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

endmodule